// File: doc/BRIEF.md
# Configurable Max-Star Log-Sum Operator

This block merges two path metrics of a log-MAP decoder into one. It takes two signed two's-complement fixed-point metrics and returns an approximation of ln(e^a + e^b). It sits in the forward and backward state-metric recursions, where it runs once per trellis branch merge. A two-bit run-time select picks one of three algorithms:
- the larger metric plus a small correction term read from a lookup table;
- the larger metric alone;
- the larger metric scaled by 0.75.

Metric width is set by an integer-bit count (sign included) and a fraction-bit count. Sensible values are 6 to 9 integer bits and 1 to 4 fraction bits. The integer width should exceed the soft-input integer width by at least 3, and the fraction width should be at least the soft-input fraction width. An elaboration parameter chooses between a purely combinational operator and one with a single output register. The full recursion, metric normalisation and windowing belong to the surrounding datapath.

Top module: `mxs_logsum`

## Requirements
- R1: With PIPE=1, while rst_n is low the registered output `sum_o` is 0 after every clock edge.
- R2: With mode 0 (max-star), the result is max(a,b) plus a correction. The correction is looked up from a table with index k = floor(|a-b| / 0.5). For k = 0..7 the table holds, in sixteenths, 11, 8, 5, 3, 2, 1, 1, 0. The correction added to the result is floor(entry * 2^FRAC_W / 16) LSBs.
- R3: With mode 1 (max), the result is exactly the larger of the two operands, compared as signed values.
- R4: In mode 0, a sum that exceeds the most positive representable value saturates to that value, (2^(W-1)-1) LSBs, where W = INT_W+FRAC_W. It does not wrap.
- R5: With mode 2 (max-scale), the result is 0.75 times the larger operand, truncated toward zero. It never grows in magnitude and never changes sign.
- R6: Mode 3 is reserved and gives the same result as mode 1.
- R7: With PIPE=1, `sum_o` presents one clock later the result computed for the operands and mode applied in the previous cycle. With PIPE=0, `sum_o` follows the inputs combinationally.
- R8: In mode 0, when |a-b| is at least 4.0 (table index 8 or more), the correction is zero and the result equals max(a,b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mode_i | input | 2 | Algorithm select: 0 max-star, 1 max, 2 max-scale, 3 reserved (acts as max) |
| a_i | input | INT_W+FRAC_W | First metric, two's complement, FRAC_W fraction bits |
| b_i | input | INT_W+FRAC_W | Second metric, two's complement, FRAC_W fraction bits |
| sum_o | output | INT_W+FRAC_W | Merged metric in the same format |

## Verification
The bench builds two copies with INT_W=4 and FRAC_W=2, one with PIPE=0 and one with PIPE=1. Each operand then has only 64 codes, so every operand pair is applied in all four modes (16384 cases) to both copies. The sweep therefore covers every correction-table index, the far-difference zero region, positive saturation at the top code, and the sign-preserving truncation of negative scaled values. The registered copy also shows the one-cycle output delay and the reset value.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

  typedef enum logic [1:0] {
    MXS_STAR  = 2'd0,
    MXS_MAX   = 2'd1,
    MXS_SCALE = 2'd2,
    MXS_RSVD  = 2'd3
  } mxs_mode_e;

  localparam int unsigned CORR_ENTRIES = 8;
  localparam int unsigned CORR_FRAC    = 4;

  // ln(1+e^-d) sampled at d = k/2, stored in sixteenths
  function automatic logic [3:0] corr_sixteenths(input logic [2:0] k);
    logic [3:0] v;
    case (k)
      3'd0:    v = 4'd11;
      3'd1:    v = 4'd8;
      3'd2:    v = 4'd5;
      3'd3:    v = 4'd3;
      3'd4:    v = 4'd2;
      3'd5:    v = 4'd1;
      3'd6:    v = 4'd1;
      default: v = 4'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mxs_corr_lut.sv
module mxs_corr_lut #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 3
) (
  input  logic signed [INT_W+FRAC_W-1:0] a_i,
  input  logic signed [INT_W+FRAC_W-1:0] b_i,
  output logic        [INT_W+FRAC_W:0]   absdiff_o,
  output logic        [INT_W+FRAC_W-1:0] corr_o
);
  import mxs_pkg::*;

  localparam int W     = INT_W + FRAC_W;
  localparam int SHIFT = CORR_FRAC - FRAC_W;

  logic signed [W:0] diff;
  logic        [W:0] idx_full;
  logic        [3:0] entry;

  always_comb begin
    diff      = {a_i[W-1], a_i} - {b_i[W-1], b_i};
    absdiff_o = diff[W] ? $unsigned(-diff) : $unsigned(diff);
    idx_full  = absdiff_o >> (FRAC_W - 1);
    if (idx_full >= (W+1)'(CORR_ENTRIES)) begin
      entry = 4'd0;
    end else begin
      entry = corr_sixteenths(idx_full[2:0]);
    end
    corr_o = W'(entry >> SHIFT);
  end
endmodule

// File: rtl/mxs_scale.sv
module mxs_scale #(
  parameter int W = 9
) (
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] y_o
);
  logic        [W:0]   mag;
  logic        [W+2:0] mag3;
  logic        [W+2:0] q;

  always_comb begin
    mag  = x_i[W-1] ? $unsigned(-{x_i[W-1], x_i}) : $unsigned({1'b0, x_i});
    mag3 = (W+3)'(mag) + ((W+3)'(mag) << 1);
    q    = mag3 >> 2;
    y_o  = x_i[W-1] ? -$signed(q[W-1:0]) : $signed(q[W-1:0]);
  end
endmodule

// File: rtl/mxs_out_stage.sv
module mxs_out_stage #(
  parameter int W    = 9,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (PIPE) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/mxs_logsum.sv
module mxs_logsum #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 3,
  parameter bit PIPE   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    mode_i,
  input  logic signed [INT_W+FRAC_W-1:0] a_i,
  input  logic signed [INT_W+FRAC_W-1:0] b_i,
  output logic [INT_W+FRAC_W-1:0]       sum_o
);
  import mxs_pkg::*;

  localparam int W = INT_W + FRAC_W;
  localparam logic signed [W:0] MAX_POS = (W+1)'((1 << (W-1)) - 1);

  logic signed [W-1:0] larger_w;
  logic        [W-1:0] corr_w;
  logic        [W:0]   absdiff_w;
  logic signed [W-1:0] scaled_w;
  logic signed [W:0]   star_wide;
  logic signed [W-1:0] star_w;
  logic                star_sat_w;
  logic signed [W-1:0] res_comb;

  assign larger_w = (a_i >= b_i) ? a_i : b_i;

  mxs_corr_lut #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_corr (
    .a_i       (a_i),
    .b_i       (b_i),
    .absdiff_o (absdiff_w),
    .corr_o    (corr_w)
  );

  mxs_scale #(.W(W)) u_scale (
    .x_i (larger_w),
    .y_o (scaled_w)
  );

  always_comb begin
    star_wide  = {larger_w[W-1], larger_w} + $signed({1'b0, corr_w});
    star_sat_w = star_wide > MAX_POS;
    star_w     = star_sat_w ? MAX_POS[W-1:0] : star_wide[W-1:0];
    case (mxs_mode_e'(mode_i))
      MXS_STAR:  res_comb = star_w;
      MXS_SCALE: res_comb = scaled_w;
      default:   res_comb = larger_w;
    endcase
  end

  mxs_out_stage #(.W(W), .PIPE(PIPE)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (res_comb),
    .q_o   (sum_o)
  );
endmodule

// File: rtl/mxs_logsum_chk.sv
module mxs_logsum_chk #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 3,
  parameter bit PIPE   = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    mode_i,
  input logic signed [INT_W+FRAC_W-1:0] a_i,
  input logic signed [INT_W+FRAC_W-1:0] b_i,
  input logic signed [INT_W+FRAC_W-1:0] larger_w,
  input logic        [INT_W+FRAC_W-1:0] corr_w,
  input logic        [INT_W+FRAC_W:0]   absdiff_w,
  input logic signed [INT_W+FRAC_W-1:0] res_comb,
  input logic        [INT_W+FRAC_W-1:0] sum_o
);
  localparam int W = INT_W + FRAC_W;
  localparam logic [W:0]   FAR_DIFF = (W+1)'(4 << FRAC_W);
  localparam logic [W-1:0] CORR_CAP = W'(11 >> (4 - FRAC_W));

  a_r3_max_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |-> ((res_comb == a_i || res_comb == b_i) &&
                          res_comb >= a_i && res_comb >= b_i));

  a_r6_rsvd_as_max: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3) |-> (res_comb >= a_i && res_comb >= b_i &&
                          (res_comb == a_i || res_comb == b_i)));

  a_r2_star_not_below: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |-> (res_comb >= a_i && res_comb >= b_i));

  a_r2_corr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    corr_w <= CORR_CAP);

  a_r8_far_no_corr: assert property (@(posedge clk) disable iff (!rst_n)
    (absdiff_w >= FAR_DIFF) |-> (corr_w == '0));

  a_r5_scale_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |-> (larger_w >= 0 ? (res_comb >= 0 && res_comb <= larger_w)
                                        : (res_comb <= 0 && res_comb >= larger_w)));

  generate
    if (PIPE) begin : g_pipe_chk
      a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sum_o == $past(res_comb)));
    end else begin : g_comb_chk
      a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == res_comb);
    end
  endgenerate
endmodule

bind mxs_logsum mxs_logsum_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PIPE(PIPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .larger_w  (larger_w),
  .corr_w    (corr_w),
  .absdiff_w (absdiff_w),
  .res_comb  (res_comb),
  .sum_o     (sum_o)
);

// File: tb/test_mxs_logsum.sv
`timescale 1ns/1ps
module test_mxs_logsum;
  localparam int IW = 4;
  localparam int FW = 2;
  localparam int W  = IW + FW;
  localparam int LO = -(1 << (W-1));
  localparam int HI = (1 << (W-1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode;
  logic signed [W-1:0] a, b;
  logic [W-1:0] out_comb, out_pipe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mxs_logsum #(.INT_W(IW), .FRAC_W(FW), .PIPE(1'b0)) i_mxs_logsum_c (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .a_i(a), .b_i(b), .sum_o(out_comb));

  mxs_logsum #(.INT_W(IW), .FRAC_W(FW), .PIPE(1'b1)) i_mxs_logsum (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .a_i(a), .b_i(b), .sum_o(out_pipe));

  function automatic int sixteenths(input int k);
    int t[8] = '{11, 8, 5, 3, 2, 1, 1, 0};
    return (k < 8) ? t[k] : 0;
  endfunction

  function automatic int expect_val(input int m, input int x, input int y, output string tag);
    int big, d, k, c, s;
    real dr;
    big = (x > y) ? x : y;
    d   = (x > y) ? x - y : y - x;
    dr  = real'(d) / real'(1 << FW);
    tag = "R3";
    if (m == 0) begin
      k = $rtoi(dr / 0.5);
      c = (sixteenths(k) * (1 << FW)) / 16;
      s = big + c;
      tag = (k >= 8) ? "R8" : "R2";
      if (s > HI) begin
        s = HI;
        tag = "R4";
      end
      return s;
    end else if (m == 2) begin
      tag = "R5";
      return $rtoi(0.75 * real'(big));
    end else if (m == 3) begin
      tag = "R6";
    end
    return big;
  endfunction

  task automatic check(input string tag, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s mode=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, mode, a, b, act, exp_v);
    end
  endtask

  initial begin
    int exp_v;
    string tag;
    mode = 2'd0;
    a = 6'sd20;
    b = -6'sd3;
    repeat (3) @(posedge clk);
    #1;
    // R1: registered output held at zero in reset
    check("R1", int'($signed(out_pipe)), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int x = LO; x <= HI; x++) begin
        for (int y = LO; y <= HI; y++) begin
          @(negedge clk);
          mode = m[1:0];
          a = W'(x);
          b = W'(y);
          #1;
          exp_v = expect_val(m, x, y, tag);
          check(tag, int'($signed(out_comb)), exp_v);
          @(posedge clk);
          #1;
          // R7: registered copy shows the same result one edge later
          check("R7", int'($signed(out_pipe)), exp_v);
        end
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 100000; n++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule